// File: doc/BRIEF.md
# Hit-Forecast Lookup Mode Controller

This block controls the lookup of a small set-associative tag store and picks, for each lookup, the order in which the tag and data ways are read. A 2-bit history counter forecasts whether the coming lookup will hit. A forecast hit runs the guessed-way mode. The way named by the caller's way guess is read first, one tag and one data way. Only when that guess is wrong are the other ways read, tags and data together. A forecast miss runs the phased mode. Every tag is read first, and then at most one data way, the one that matched.

Misses tend to come in clusters, so a counter that follows recent outcomes steers miss-heavy stretches toward the phased mode. That mode reads no data on a miss. Hit-heavy stretches go to the guessed-way mode, which reads only one tag and one data way when the guess is right. The block reports the hit result and the matched way. It keeps running totals of tag-way reads and data-way reads so that the array activity of each policy can be compared. A fill port writes tags into the store. The data arrays and the way guesser are outside the block, so the block counts data reads but holds no data.

Top module: `lookup_mode_ctrl`

## Requirements
- R1: After reset, reqReady is 1, respValid is 0, tagReads and dataReads are 0, every way of every set is invalid, and the history counter holds 2, so the first lookup uses the guessed-way mode.
- R2: A lookup hits when a valid way of the addressed set holds the requested tag. respWay gives the lowest-numbered such way. respWay is 0 on a miss.
- R3: The history counter is a 2-bit saturating counter. Values 2 and 3 select the guessed-way mode (respMode=1) and values 0 and 1 select the phased mode (respMode=0). Each response moves the counter up by one on a hit and down by one on a miss, saturating at 3 and 0. The new value governs the next accepted lookup.
- R4: In guessed-way mode with a correct guess, respValid rises in the cycle right after acceptance, and each counter grows by exactly 1.
- R5: In guessed-way mode with a wrong guess (a hit in another way, or a miss), respValid rises two cycles after acceptance, and each counter grows by WAYS.
- R6: In phased mode, respValid rises two cycles after acceptance. tagReads grows by WAYS, and dataReads grows by 1 on a hit and by 0 on a miss.
- R7: reqReady is 1 only while no lookup is in flight. It is 0 from the cycle after acceptance through the response cycle, and it is 1 again in the cycle after respValid.
- R8: A fill pulse writes fillTag into way fillWay of set fillSet and marks it valid. A fill of a way that is already valid replaces the old tag, so the old tag then misses.
- R9: reqSet, reqTag and reqPredWay are sampled in the cycle of acceptance. Changing them while the lookup is in flight does not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fillValid | input | 1 | Fill strobe |
| fillSet | input | SET_W | Set written by a fill |
| fillWay | input | WAY_W | Way written by a fill |
| fillTag | input | TAG_W | Tag written by a fill |
| reqValid | input | 1 | Lookup request |
| reqReady | output | 1 | Block idle, request accepted this cycle |
| reqSet | input | SET_W | Set index of the lookup |
| reqTag | input | TAG_W | Tag of the lookup |
| reqPredWay | input | WAY_W | Way guess for the lookup |
| respValid | output | 1 | Response cycle |
| respHit | output | 1 | Lookup hit |
| respWay | output | WAY_W | Matched way (0 on miss) |
| respMode | output | 1 | 1 = guessed-way mode, 0 = phased mode |
| tagReads | output | CNT_W | Running total of tag-way reads |
| dataReads | output | CNT_W | Running total of data-way reads |

## Verification
Once the store is filled, the bench sweeps every set. For each set it tries a tag held in each way and a tag that is absent, and pairs each of these with every way guess. This separates a right guess, a wrong guess that still hits, and a miss. A run of misses on the empty store drives the history counter down to 0 and holds it there. The sweep then walks the counter up through both modes, so every latency and read count is seen in both modes. Duplicate tags, tag overwrites, and inputs changed during a lookup separate the lowest-way priority, the fill replacement, and the sampling at acceptance.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;        // latch request fields
    logic chargeGuess;    // one tag + one data read (guessed way)
    logic chargeRest;     // remaining ways, tags and data
    logic chargeAllTags;  // every tag way
    logic chargeOneData;  // a single data way after tag match
  } lmcStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic guessHit;
    logic anyHit;
  } lmcStatus_t;

endpackage

// File: rtl/lmc_datapath.sv
module lmc_datapath
  import lmc_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 4,
  parameter int TAG_W = 6,
  parameter int CNT_W = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fillValid,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [TAG_W-1:0] fillTag,
  input  logic [SET_W-1:0] reqSet,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [WAY_W-1:0] reqPredWay,
  input  lmcStrobe_t       strobe,
  output lmcStatus_t       status,
  output logic [WAY_W-1:0] hitWay,
  output logic [CNT_W-1:0] tagReads,
  output logic [CNT_W-1:0] dataReads
);

  localparam logic [CNT_W-1:0] INC_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] INC_REST = CNT_W'(WAYS - 1);
  localparam logic [CNT_W-1:0] INC_ALL  = CNT_W'(WAYS);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [SET_W-1:0] curSet;
  logic [TAG_W-1:0] curTag;
  logic [WAY_W-1:0] curGuess;
  logic [WAYS-1:0]  matchVec;
  logic [CNT_W-1:0] tagInc, dataInc;

  always_ff @(posedge clk) begin
    if (fillValid) tagMem[fillSet][fillWay] <= fillTag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (fillValid) begin
      validMem[fillSet][fillWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curSet   <= '0;
      curTag   <= '0;
      curGuess <= '0;
    end else if (strobe.capture) begin
      curSet   <= reqSet;
      curTag   <= reqTag;
      curGuess <= reqPredWay;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign matchVec[w] = validMem[curSet][w] && (tagMem[curSet][w] == curTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) hitWay = WAY_W'(w);
    end
  end

  assign status.guessHit = matchVec[curGuess];
  assign status.anyHit   = |matchVec;

  always_comb begin
    tagInc  = '0;
    dataInc = '0;
    if (strobe.chargeGuess)   begin tagInc += INC_ONE;  dataInc += INC_ONE;  end
    if (strobe.chargeRest)    begin tagInc += INC_REST; dataInc += INC_REST; end
    if (strobe.chargeAllTags) tagInc  += INC_ALL;
    if (strobe.chargeOneData) dataInc += INC_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tagReads  <= '0;
      dataReads <= '0;
    end else begin
      tagReads  <= tagReads + tagInc;
      dataReads <= dataReads + dataInc;
    end
  end

endmodule

// File: rtl/lmc_control.sv
module lmc_control
  import lmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  output logic       reqReady,
  input  lmcStatus_t status,
  output lmcStrobe_t strobe,
  output logic       respValid,
  output logic       respMode
);

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} lmcState_t;

  lmcState_t stateQ, stateD;
  logic       modeQ;     // 1 = guessed-way mode
  logic [1:0] histCnt;

  assign reqReady = (stateQ == ST_IDLE);
  assign respMode = modeQ;

  always_comb begin
    strobe               = '0;
    strobe.capture       = reqValid && reqReady;
    respValid            = 1'b0;
    stateD               = stateQ;
    unique case (stateQ)
      ST_IDLE: if (strobe.capture) stateD = ST_FIRST;
      ST_FIRST: begin
        strobe.chargeGuess   = modeQ;
        strobe.chargeAllTags = !modeQ;
        if (modeQ && status.guessHit) begin
          respValid = 1'b1;
          stateD    = ST_IDLE;
        end else begin
          stateD = ST_SECOND;
        end
      end
      ST_SECOND: begin
        strobe.chargeRest    = modeQ;
        strobe.chargeOneData = !modeQ && status.anyHit;
        respValid            = 1'b1;
        stateD               = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ  <= ST_IDLE;
      modeQ   <= 1'b1;
      histCnt <= 2'd2;
    end else begin
      stateQ <= stateD;
      if (strobe.capture) modeQ <= histCnt[1];
      if (respValid) begin
        if (status.anyHit) begin
          if (histCnt != 2'd3) histCnt <= histCnt + 2'd1;
        end else begin
          if (histCnt != 2'd0) histCnt <= histCnt - 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/lookup_mode_ctrl.sv
module lookup_mode_ctrl
  import lmc_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 4,
  parameter int TAG_W = 6,
  parameter int CNT_W = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fillValid,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [TAG_W-1:0] fillTag,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [SET_W-1:0] reqSet,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [WAY_W-1:0] reqPredWay,
  output logic             respValid,
  output logic             respHit,
  output logic [WAY_W-1:0] respWay,
  output logic             respMode,
  output logic [CNT_W-1:0] tagReads,
  output logic [CNT_W-1:0] dataReads
);

  lmcStrobe_t strobe;
  lmcStatus_t status;

  lmc_control u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .status    (status),
    .strobe    (strobe),
    .respValid (respValid),
    .respMode  (respMode)
  );

  lmc_datapath #(
    .WAYS (WAYS), .SETS (SETS), .TAG_W (TAG_W), .CNT_W (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .fillValid  (fillValid),
    .fillSet    (fillSet),
    .fillWay    (fillWay),
    .fillTag    (fillTag),
    .reqSet     (reqSet),
    .reqTag     (reqTag),
    .reqPredWay (reqPredWay),
    .strobe     (strobe),
    .status     (status),
    .hitWay     (respWay),
    .tagReads   (tagReads),
    .dataReads  (dataReads)
  );

  assign respHit = status.anyHit;

endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic             respValid,
  input logic             respHit,
  input logic [WAY_W-1:0] respWay,
  input logic             respMode,
  input logic [CNT_W-1:0] tagReads,
  input logic [CNT_W-1:0] dataReads
);

  localparam logic [CNT_W-1:0] MAX_STEP = CNT_W'(WAYS);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);                                   // R7

  AST_RESP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> !reqReady);                                                // R7

  AST_MISS_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && !respHit) |-> (respWay == '0));                            // R2

  AST_PHASED_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && !respMode) |-> !$past(reqValid && reqReady));              // R6

  AST_PHASED_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && !respMode && !respHit) |=> (dataReads == $past(dataReads))); // R6

  AST_FAST_RESP_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && $past(reqValid && reqReady)) |=>
      (tagReads == $past(tagReads) + CNT_W'(1)));                            // R4

  AST_TAG_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tagReads - $past(tagReads)) <= MAX_STEP));                    // R5

endmodule

bind lookup_mode_ctrl lmc_checker #(
  .WAYS (WAYS), .WAY_W (WAY_W), .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .respValid (respValid),
  .respHit   (respHit),
  .respWay   (respWay),
  .respMode  (respMode),
  .tagReads  (tagReads),
  .dataReads (dataReads)
);

// File: tb/lookup_mode_ctrl_test.sv
module lookup_mode_ctrl_test;

  localparam int WAYS  = 4;
  localparam int SETS  = 4;
  localparam int TAG_W = 6;
  localparam int CNT_W = 16;
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fillValid = 1'b0;
  logic [SET_W-1:0] fillSet = '0;
  logic [WAY_W-1:0] fillWay = '0;
  logic [TAG_W-1:0] fillTag = '0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [SET_W-1:0] reqSet = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic [WAY_W-1:0] reqPredWay = '0;
  logic             respValid, respHit, respMode;
  logic [WAY_W-1:0] respWay;
  logic [CNT_W-1:0] tagReads, dataReads;

  lookup_mode_ctrl #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay), .fillTag(fillTag),
    .reqValid(reqValid), .reqReady(reqReady), .reqSet(reqSet), .reqTag(reqTag),
    .reqPredWay(reqPredWay), .respValid(respValid), .respHit(respHit),
    .respWay(respWay), .respMode(respMode), .tagReads(tagReads), .dataReads(dataReads)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int mTag   [SETS][WAYS];
  bit mValid [SETS][WAYS];
  int mHist  = 2;
  int mTagRd = 0;
  int mDataRd = 0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doFill(int s, int w, int t);
    @(negedge clk);
    fillValid = 1'b1;
    fillSet = SET_W'(s); fillWay = WAY_W'(w); fillTag = TAG_W'(t);
    @(negedge clk);
    fillValid = 1'b0;
    mTag[s][w] = t; mValid[s][w] = 1'b1;
  endtask

  task automatic doLookup(int s, int t, int pw);
    bit expMode, expHit, guessOk;
    int expWay, expLat, lat;
    expMode = (mHist >= 2);
    expHit = 1'b0; expWay = 0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (mValid[s][w] && mTag[s][w] == t) begin expHit = 1'b1; expWay = w; end
    guessOk = mValid[s][pw] && (mTag[s][pw] == t);
    if (expMode) begin
      expLat = guessOk ? 1 : 2;
      mTagRd  += guessOk ? 1 : WAYS;
      mDataRd += guessOk ? 1 : WAYS;
    end else begin
      expLat = 2;
      mTagRd  += WAYS;
      mDataRd += expHit ? 1 : 0;
    end
    @(negedge clk);
    check("R7 ready when idle", int'(reqReady), 1);
    reqValid = 1'b1;
    reqSet = SET_W'(s); reqTag = TAG_W'(t); reqPredWay = WAY_W'(pw);
    @(negedge clk);
    // R9: disturb request fields while the lookup is in flight
    reqValid = 1'b0;
    reqSet = SET_W'(s + 1); reqTag = TAG_W'(t + 7); reqPredWay = WAY_W'(pw + 1);
    lat = 1;
    while (!respValid && lat < 5) begin
      @(negedge clk);
      lat++;
    end
    check("R4/R5/R6 latency", lat, expLat);
    check("R2/R9 hit", int'(respHit), int'(expHit));
    check("R2/R9 way", int'(respWay), expWay);
    check("R3 mode", int'(respMode), int'(expMode));
    check("R7 busy during response", int'(reqReady), 0);
    @(negedge clk);
    check("R7 ready after response", int'(reqReady), 1);
    check("R4/R5/R6 tag reads", int'(tagReads), mTagRd);
    check("R4/R5/R6 data reads", int'(dataReads), mDataRd);
    if (expHit) begin if (mHist < 3) mHist++; end
    else begin if (mHist > 0) mHist--; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mTag[s][w] = 0; mValid[s][w] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(reqReady), 1);
    check("R1 respValid", int'(respValid), 0);
    check("R1 tagReads", int'(tagReads), 0);
    check("R1 dataReads", int'(dataReads), 0);

    // R1/R3: empty store misses; counter starts in guessed-way mode, falls, saturates at 0
    for (int i = 0; i < 6; i++) doLookup(i % SETS, 5 + i, i % WAYS);

    // fill every way
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) doFill(s, w, s * 8 + w + 1);

    // sweep: each set, each resident way plus an absent tag, each guess
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w <= WAYS; w++)
        for (int pw = 0; pw < WAYS; pw++)
          doLookup(s, (w == WAYS) ? 60 : s * 8 + w + 1, pw);

    // R3: long hit run saturates high, then misses bring the phased mode back
    for (int i = 0; i < 5; i++) doLookup(2, 2 * 8 + 1, 1);
    for (int i = 0; i < 4; i++) doLookup(2, 61, 0);
    for (int i = 0; i < 3; i++) doLookup(2, 2 * 8 + 3, 0);

    // R8: overwrite a valid way; old tag misses, new tag hits there
    doFill(1, 2, 45);
    doLookup(1, 45, 2);
    doLookup(1, 1 * 8 + 2 + 1, 2);
    doLookup(1, 45, 0);

    // R2: duplicate tag in ways 1 and 3 reports the lowest way
    doFill(0, 3, 0 * 8 + 1 + 1);
    doLookup(0, 2, 3);
    doLookup(0, 2, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule